// File: doc/BRIEF.md
# Spare Row/Column Repair Search Engine

This block runs once a memory self-test has finished and the faults found by that test are sitting in an external fault list. The memory has a number of spare rows and spare columns. Some of them are already committed by an earlier must-repair step, and those addresses come in as inputs. The engine then looks for a way to spend the remaining spares so that every listed fault lies on a replaced row or a replaced column. If it finds one, it reports the chosen addresses. If it does not, it reports that the memory cannot be repaired.

The search tries candidate plans one after another. A plan is a bit string with one bit per free spare. A set bit means "spend a row" and a clear bit means "spend a column". Every plan has exactly as many ones as there are free rows. For each plan, the engine resets its two address CAMs to the saved must-repair state. It then walks the fault list one entry per clock. A fault that already matches a CAM entry costs nothing. An uncovered fault spends the next unused plan bit. When a plan runs out of bits, or tries to insert into a full CAM, the engine moves to the next plan and restarts.

The fault list is read through an index output and a combinational row/column return. Results stay fixed until reset.

Top module: `repair_solver`

## Requirements
- R1: While reset is high and after reset, `done` and `repairable` are 0, and both valid vectors are 0.
- R2: No search starts until `bist_done` is high. While it stays low, `done` stays 0.
- R3: The must-repair addresses occupy CAM entries 0 to count-1, in input order, in every reported solution.
- R4: A fault whose row matches a row-CAM entry, or whose column matches a column-CAM entry, spends no spare.
- R5: An uncovered fault spends the next unused plan bit, counted from bit 0. A 1 inserts the fault row into the lowest free row entry. A 0 inserts the fault column into the lowest free column entry.
- R6: Let L be the number of free rows plus free columns. The first plan has its low bits set, one per free row, within L bits. Each following plan is the next larger L-bit value with the same number of ones. The first plan that covers every fault is the one reported.
- R7: A plan fails when it has no unused bit left for an uncovered fault, or when the chosen CAM is full. After a failure, both CAMs are restored to the must-repair state and the fault list is replayed from index 0.
- R8: When the largest plan fails, `done` is 1, `repairable` is 0, and both valid vectors are 0.
- R9: `repairable` is 1 exactly when some choice of at most the free rows and at most the free columns covers every fault not already covered by the must-repair addresses.
- R10: With a fault count of 0, the engine reports success with only the must-repair entries valid.
- R11: Once `done` is 1, it stays 1 until reset. From then on, `repairable` and all address and valid outputs hold still, whatever `bist_done` does.
- R12: Each valid vector is always contiguous from entry 0, meaning it has the form 2^k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_done | input | 1 | Self-test finished; starts the search |
| mr_row_cnt | input | clog2(SPARE_R+1) | Number of must-repair rows |
| mr_row_addr | input | SPARE_R*ROW_W | Must-repair row addresses, entry 0 in the low bits |
| mr_col_cnt | input | clog2(SPARE_C+1) | Number of must-repair columns |
| mr_col_addr | input | SPARE_C*COL_W | Must-repair column addresses, entry 0 in the low bits |
| fault_count | input | clog2(MAX_FAULTS+1) | Number of entries in the fault list |
| fault_idx | output | clog2(MAX_FAULTS+1) | Index of the fault-list entry being read |
| fault_row | input | ROW_W | Row of entry `fault_idx` (same-cycle return) |
| fault_col | input | COL_W | Column of entry `fault_idx` (same-cycle return) |
| done | output | 1 | Search finished |
| repairable | output | 1 | A covering solution was found |
| row_valid | output | SPARE_R | Valid bit per row-spare entry |
| row_addr | output | SPARE_R*ROW_W | Row-spare addresses, entry 0 in the low bits |
| col_valid | output | SPARE_C | Valid bit per column-spare entry |
| col_addr | output | SPARE_C*COL_W | Column-spare addresses, entry 0 in the low bits |

## Verification
Internal state shows up at the ports in specific ways:
- A plan register that steps wrongly appears as a different reported solution for a case whose plan order is fixed, or as a wrong repairable verdict once the search is exhausted.
- A restore that leaves stale entries behind appears as extra valid addresses, or as spares that are not needed.
- Broken coverage matching appears as a solution that misses a listed fault.

Each of these is visible as soon as `done` rises, which takes at most a few dozen clocks in the small configuration. The sweep compares every verdict against an arithmetic cover search. It also checks that each reported solution covers every fault, while directed cases pin down the exact entries.

// File: rtl/rsolve_pkg.sv
package rsolve_pkg;

    localparam int SW = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESTORE,
        ST_SCAN,
        ST_DONE
    } solve_state_t;

    // Low k bits set
    function automatic logic [SW-1:0] thermo(input int k);
        logic [SW-1:0] t;
        for (int i = 0; i < SW; i++) t[i] = (i < k);
        return t;
    endfunction

    // Next larger value within len bits having the same number of ones
    function automatic logic [SW-1:0] next_comb(input logic [SW-1:0] s, input int len);
        logic [SW-1:0] res;
        int piv;
        int ones;
        piv  = -1;
        ones = 0;
        for (int p = 0; p < SW-1; p++) begin
            if (piv < 0 && s[p]) begin
                if (!s[p+1] && (p + 1) < len) piv = p;
                else ones++;
            end
        end
        res = s;
        if (piv >= 0) begin
            for (int q = 0; q < SW; q++) begin
                if (q == piv + 1) res[q] = 1'b1;
                else if (q <= piv) res[q] = (q < ones);
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/addr_cam.sv
module addr_cam #(
    parameter int ENTRIES = 2,
    parameter int AW      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restore,
    input  logic [ENTRIES-1:0]    ld_valid,
    input  logic [ENTRIES*AW-1:0] ld_addr,
    input  logic                  insert,
    input  logic [AW-1:0]         ins_addr,
    input  logic [AW-1:0]         key,
    output logic                  hit,
    output logic                  full,
    output logic [ENTRIES-1:0]    valid_o,
    output logic [ENTRIES*AW-1:0] addr_o
);
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic          v_q;
        logic [AW-1:0] a_q;
        logic          prev_ok;

        if (i == 0) begin : g_first
            assign prev_ok = 1'b1;
        end else begin : g_rest
            assign prev_ok = valid_o[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                a_q <= '0;
            end else if (restore) begin
                v_q <= ld_valid[i];
                a_q <= ld_addr[i*AW +: AW];
            end else if (insert && !v_q && prev_ok) begin
                v_q <= 1'b1;
                a_q <= ins_addr;
            end
        end

        assign valid_o[i]         = v_q;
        assign addr_o[i*AW +: AW] = a_q;
        assign match[i]           = v_q && (a_q == key);
    end

    assign hit  = |match;
    assign full = &valid_o;
endmodule

// File: rtl/strat_gen.sv
module strat_gen
    import rsolve_pkg::*;
#(
    parameter int N  = 4,
    parameter int NW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic [NW-1:0] init_rows,
    input  logic          advance,
    input  logic [NW-1:0] len,
    input  logic [NW-1:0] rows,
    output logic [N-1:0]  strat,
    output logic          is_last
);
    logic [SW-1:0] last_w;
    logic [SW-1:0] next_w;
    logic [SW-1:0] first_w;

    assign first_w = thermo(int'(init_rows));
    assign last_w  = thermo(int'(rows)) << (len - rows);
    assign next_w  = next_comb(SW'(strat), int'(len));
    assign is_last = (SW'(strat) == last_w);

    always_ff @(posedge clk) begin
        if (rst)          strat <= '0;
        else if (init)    strat <= first_w[N-1:0];
        else if (advance) strat <= next_w[N-1:0];
    end
endmodule

// File: rtl/repair_solver.sv
module repair_solver
    import rsolve_pkg::*;
#(
    parameter int ROW_W      = 3,
    parameter int COL_W      = 3,
    parameter int SPARE_R    = 2,
    parameter int SPARE_C    = 2,
    parameter int MAX_FAULTS = 6,
    localparam int RCW       = $clog2(SPARE_R + 1),
    localparam int CCW       = $clog2(SPARE_C + 1),
    localparam int FIW       = $clog2(MAX_FAULTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bist_done,
    input  logic [RCW-1:0]           mr_row_cnt,
    input  logic [SPARE_R*ROW_W-1:0] mr_row_addr,
    input  logic [CCW-1:0]           mr_col_cnt,
    input  logic [SPARE_C*COL_W-1:0] mr_col_addr,
    input  logic [FIW-1:0]           fault_count,
    output logic [FIW-1:0]           fault_idx,
    input  logic [ROW_W-1:0]         fault_row,
    input  logic [COL_W-1:0]         fault_col,
    output logic                     done,
    output logic                     repairable,
    output logic [SPARE_R-1:0]       row_valid,
    output logic [SPARE_R*ROW_W-1:0] row_addr,
    output logic [SPARE_C-1:0]       col_valid,
    output logic [SPARE_C*COL_W-1:0] col_addr
);
    localparam int N  = SPARE_R + SPARE_C;
    localparam int NW = $clog2(N + 1);

    solve_state_t state;

    // Shadow copy of the post-must-repair state
    logic [SPARE_R-1:0]       sv_rvalid;
    logic [SPARE_R*ROW_W-1:0] sv_raddr;
    logic [SPARE_C-1:0]       sv_cvalid;
    logic [SPARE_C*COL_W-1:0] sv_caddr;
    logic [NW-1:0]            len_q, rows_q;

    logic [NW-1:0]  ptr;
    logic [FIW-1:0] idx;
    logic           rep_q;

    logic [NW-1:0]  rows_init, len_init;
    logic [N-1:0]   strat;
    logic [SW-1:0]  strat_w;
    logic           is_last, sym;
    logic           start, restore, scanning, list_end, covered, plan_fail;
    logic           ins_row, ins_col, advance;
    logic           row_hit, col_hit, row_full, col_full;
    logic [SPARE_R-1:0] cam_rvalid;
    logic [SPARE_C-1:0] cam_cvalid;

    assign rows_init = NW'(SPARE_R) - NW'(mr_row_cnt);
    assign len_init  = rows_init + NW'(SPARE_C) - NW'(mr_col_cnt);

    assign start     = (state == ST_IDLE) && bist_done;
    assign restore   = (state == ST_RESTORE);
    assign scanning  = (state == ST_SCAN);
    assign list_end  = (idx == fault_count);
    assign covered   = row_hit || col_hit;
    assign strat_w   = SW'(strat);
    assign sym       = strat_w[ptr];
    assign plan_fail = !covered && ((ptr >= len_q) || (sym ? row_full : col_full));
    assign ins_row   = scanning && !list_end && !plan_fail && !covered && sym;
    assign ins_col   = scanning && !list_end && !plan_fail && !covered && !sym;
    assign advance   = scanning && !list_end && plan_fail && !is_last;

    strat_gen #(.N(N), .NW(NW)) u_strat (
        .clk      (clk),
        .rst      (rst),
        .init     (start),
        .init_rows(rows_init),
        .advance  (advance),
        .len      (len_q),
        .rows     (rows_q),
        .strat    (strat),
        .is_last  (is_last)
    );

    addr_cam #(.ENTRIES(SPARE_R), .AW(ROW_W)) u_row_cam (
        .clk     (clk),
        .rst     (rst),
        .restore (restore),
        .ld_valid(sv_rvalid),
        .ld_addr (sv_raddr),
        .insert  (ins_row),
        .ins_addr(fault_row),
        .key     (fault_row),
        .hit     (row_hit),
        .full    (row_full),
        .valid_o (cam_rvalid),
        .addr_o  (row_addr)
    );

    addr_cam #(.ENTRIES(SPARE_C), .AW(COL_W)) u_col_cam (
        .clk     (clk),
        .rst     (rst),
        .restore (restore),
        .ld_valid(sv_cvalid),
        .ld_addr (sv_caddr),
        .insert  (ins_col),
        .ins_addr(fault_col),
        .key     (fault_col),
        .hit     (col_hit),
        .full    (col_full),
        .valid_o (cam_cvalid),
        .addr_o  (col_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sv_rvalid <= '0;
            sv_raddr  <= '0;
            sv_cvalid <= '0;
            sv_caddr  <= '0;
            len_q     <= '0;
            rows_q    <= '0;
            ptr       <= '0;
            idx       <= '0;
            rep_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (bist_done) begin
                    sv_rvalid <= thermo(int'(mr_row_cnt))[SPARE_R-1:0];
                    sv_raddr  <= mr_row_addr;
                    sv_cvalid <= thermo(int'(mr_col_cnt))[SPARE_C-1:0];
                    sv_caddr  <= mr_col_addr;
                    len_q     <= len_init;
                    rows_q    <= rows_init;
                    state     <= ST_RESTORE;
                end
                ST_RESTORE: begin
                    ptr   <= '0;
                    idx   <= '0;
                    state <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (list_end) begin
                        rep_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (covered) begin
                        idx <= idx + 1'b1;
                    end else if (plan_fail) begin
                        state <= is_last ? ST_DONE : ST_RESTORE;
                    end else begin
                        ptr <= ptr + 1'b1;
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    assign fault_idx  = idx;
    assign done       = (state == ST_DONE);
    assign repairable = rep_q;
    assign row_valid  = (done && rep_q) ? cam_rvalid : '0;
    assign col_valid  = (done && rep_q) ? cam_cvalid : '0;
endmodule

// File: rtl/repair_solver_chk.sv
module repair_solver_chk #(
    parameter int ROW_W   = 3,
    parameter int COL_W   = 3,
    parameter int SPARE_R = 2,
    parameter int SPARE_C = 2,
    parameter int FIW     = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic [FIW-1:0]           fault_idx,
    input logic [FIW-1:0]           fault_count,
    input logic                     done,
    input logic                     repairable,
    input logic [SPARE_R-1:0]       row_valid,
    input logic [SPARE_R*ROW_W-1:0] row_addr,
    input logic [SPARE_C-1:0]       col_valid,
    input logic [SPARE_C*COL_W-1:0] col_addr
);
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_result_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> ($stable(row_addr) && $stable(col_addr)
                                   && $stable(repairable) && $stable(row_valid)));

    p_rep_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
        repairable |-> done);

    p_valid_only_success_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && repairable) |-> (row_valid == '0 && col_valid == '0));

    p_row_contig_r12: assert property (@(posedge clk) disable iff (rst)
        (row_valid & (row_valid + SPARE_R'(1))) == '0);

    p_col_contig_r12: assert property (@(posedge clk) disable iff (rst)
        (col_valid & (col_valid + SPARE_C'(1))) == '0);

    p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
        fault_idx <= fault_count);
endmodule

bind repair_solver repair_solver_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W), .SPARE_R(SPARE_R), .SPARE_C(SPARE_C), .FIW(FIW)
) u_chk (.*);

// File: tb/repair_solver_bench.sv
module repair_solver_bench;
    localparam int ROW_W = 3, COL_W = 3, SR = 2, SC = 2, MF = 6;
    localparam int RCW = $clog2(SR + 1), CCW = $clog2(SC + 1), FIW = $clog2(MF + 1);

    logic clk = 1'b0, rst = 1'b1, bist_done = 1'b0;
    logic [RCW-1:0] mr_row_cnt;
    logic [CCW-1:0] mr_col_cnt;
    logic [SR*ROW_W-1:0] mr_row_addr, row_addr;
    logic [SC*COL_W-1:0] mr_col_addr, col_addr;
    logic [FIW-1:0] fault_count, fault_idx;
    logic [ROW_W-1:0] fault_row;
    logic [COL_W-1:0] fault_col;
    logic done, repairable;
    logic [SR-1:0] row_valid;
    logic [SC-1:0] col_valid;

    int checks = 0, failures = 0;
    int nf;
    logic [2:0] frow [0:7];
    logic [2:0] fcol [0:7];

    always #10 clk = ~clk;

    assign fault_row = frow[fault_idx];
    assign fault_col = fcol[fault_idx];

    repair_solver #(.ROW_W(ROW_W), .COL_W(COL_W), .SPARE_R(SR), .SPARE_C(SC), .MAX_FAULTS(MF))
    u_repair_solver (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    task automatic setup(input int rc, input int r0, input int r1,
                         input int cc, input int c0, input int c1);
        rst = 1'b1;
        bist_done = 1'b0;
        mr_row_cnt  = RCW'(rc);
        mr_row_addr = {3'(r1), 3'(r0)};
        mr_col_cnt  = CCW'(cc);
        mr_col_addr = {3'(c1), 3'(c0)};
        fault_count = FIW'(nf);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(output bit finished);
        finished = 1'b0;
        bist_done = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin
                finished = 1'b1;
                break;
            end
        end
    endtask

    function automatic bit ref_ok(input int rc, input int r0, input int r1,
                                  input int cc, input int c0, input int c1);
        int rleft = SR - rc, cleft = SC - cc;
        for (int rs = 0; rs < 256; rs++) begin
            logic [7:0] need = '0;
            if ($countones(rs) > rleft) continue;
            for (int f = 0; f < nf; f++) begin
                int r = int'(frow[f]), c = int'(fcol[f]);
                if ((rc > 0 && r == r0) || (rc > 1 && r == r1)) continue;
                if ((cc > 0 && c == c0) || (cc > 1 && c == c1)) continue;
                if (rs[r]) continue;
                need[c] = 1'b1;
            end
            if ($countones(need) <= cleft) return 1'b1;
        end
        return 1'b0;
    endfunction

    initial begin
        bit fin;
        for (int i = 0; i < 8; i++) begin frow[i] = '0; fcol[i] = '0; end
        nf = 0;
        setup(0, 0, 0, 0, 0, 0);
        // R1 reset state
        chk(!done && !repairable, "R1 flags", {done, repairable}, 0);
        chk(row_valid == 0 && col_valid == 0, "R1 valid", {row_valid, col_valid}, 0);
        // R2 no start without bist_done
        repeat (20) @(negedge clk);
        chk(!done, "R2 idle", done, 0);

        // R5 R6: plan 0011 -> row1,row2,col3
        nf = 3;
        frow[0] = 1; fcol[0] = 1; frow[1] = 2; fcol[1] = 2; frow[2] = 3; fcol[2] = 3;
        setup(0, 0, 0, 0, 0, 0);
        run(fin);
        chk(fin && repairable, "R6 caseA rep", repairable, 1);
        chk(row_valid == 2'b11 && row_addr == {3'd2, 3'd1}, "R5 caseA rows", row_addr, {3'd2, 3'd1});
        chk(col_valid == 2'b01 && col_addr[2:0] == 3'd3, "R5 caseA cols", col_addr[2:0], 3);

        // R3 R4: must-repair row 5, plan 001
        frow[0] = 5; fcol[0] = 0; frow[1] = 1; fcol[1] = 1; frow[2] = 2; fcol[2] = 2;
        setup(1, 5, 0, 0, 0, 0);
        run(fin);
        chk(fin && repairable, "R3 caseB rep", repairable, 1);
        chk(row_valid == 2'b11 && row_addr == {3'd1, 3'd5}, "R3 R4 caseB rows", row_addr, {3'd1, 3'd5});
        chk(col_valid == 2'b01 && col_addr[2:0] == 3'd2, "R4 caseB cols", col_addr[2:0], 2);

        // R7: plan 01 fails, plan 10 -> col0,row2 after restore
        frow[0] = 0; fcol[0] = 0; frow[1] = 1; fcol[1] = 0; frow[2] = 2; fcol[2] = 1;
        setup(1, 7, 0, 1, 7, 0);
        run(fin);
        chk(fin && repairable, "R7 caseC rep", repairable, 1);
        chk(row_valid == 2'b11 && row_addr == {3'd2, 3'd7}, "R7 caseC rows", row_addr, {3'd2, 3'd7});
        chk(col_valid == 2'b11 && col_addr == {3'd0, 3'd7}, "R7 caseC cols", col_addr, {3'd0, 3'd7});

        // R8 unrepairable
        frow[0] = 0; fcol[0] = 0; frow[1] = 1; fcol[1] = 1; frow[2] = 2; fcol[2] = 2;
        setup(1, 7, 0, 1, 7, 0);
        run(fin);
        chk(fin && !repairable, "R8 verdict", repairable, 0);
        chk(row_valid == 0 && col_valid == 0, "R8 valid", {row_valid, col_valid}, 0);

        // R10 empty list
        nf = 0;
        setup(1, 3, 0, 0, 0, 0);
        run(fin);
        chk(fin && repairable, "R10 rep", repairable, 1);
        chk(row_valid == 2'b01 && row_addr[2:0] == 3'd3 && col_valid == 0, "R10 entries", row_addr[2:0], 3);

        // R11 sticky result under bist_done toggling
        for (int k = 0; k < 10; k++) begin
            bist_done = ~bist_done;
            @(negedge clk);
            chk(done && repairable && row_valid == 2'b01 && row_addr[2:0] == 3'd3, "R11 hold", done, 1);
        end

        // R9 R12 sweep against arithmetic cover search
        for (int t = 0; t < 400; t++) begin
            int rc = $urandom_range(0, 2), cc = $urandom_range(0, 2);
            int lim = (t % 2 == 0) ? 3 : 7;
            int r0 = $urandom_range(0, 7), r1 = $urandom_range(0, 7);
            int c0 = $urandom_range(0, 7), c1 = $urandom_range(0, 7);
            bit exp_ok;
            nf = $urandom_range(0, MF);
            for (int f = 0; f < MF; f++) begin
                frow[f] = 3'($urandom_range(0, lim));
                fcol[f] = 3'($urandom_range(0, lim));
            end
            exp_ok = ref_ok(rc, r0, r1, cc, c0, c1);
            setup(rc, r0, r1, cc, c0, c1);
            run(fin);
            chk(fin && repairable == exp_ok, "R9 verdict", repairable, exp_ok);
            chk((row_valid & (row_valid + 1'b1)) == 0 && (col_valid & (col_valid + 1'b1)) == 0,
                "R12 contiguous", {row_valid, col_valid}, 0);
            if (exp_ok && repairable) begin
                bit all_cov = 1'b1;
                for (int f = 0; f < nf; f++) begin
                    bit c = 1'b0;
                    for (int e = 0; e < SR; e++)
                        if (row_valid[e] && row_addr[e*3 +: 3] == frow[f]) c = 1'b1;
                    for (int e = 0; e < SC; e++)
                        if (col_valid[e] && col_addr[e*3 +: 3] == fcol[f]) c = 1'b1;
                    if (!c) all_cov = 1'b0;
                end
                chk(all_cov, "R9 coverage", all_cov, 1);
                chk((rc < 1 || (row_valid[0] && row_addr[2:0] == 3'(r0))) &&
                    (rc < 2 || (row_valid[1] && row_addr[5:3] == 3'(r1))) &&
                    (cc < 1 || (col_valid[0] && col_addr[2:0] == 3'(c0))) &&
                    (cc < 2 || (col_valid[1] && col_addr[5:3] == 3'(c1))),
                    "R3 sweep", row_addr, r0);
            end
        end
        finish_run();
    end
endmodule